// File: doc/BRIEF.md
# Fixed-Slot Round-Robin Memory Arbiter

Eight processor cores share one synchronous 32-bit memory through this block. A slot pointer steps through the cores in a fixed rotation at a constant rate. It keeps stepping whether or not any core is requesting, so every core gets the same access period and can predict exactly when its next access will happen. A core that is idle or stopped still owns its slot, and that slot simply passes unused.

A core raises its request together with an address, write data and a write strobe, and holds them until its slot arrives. In the first clock of its slot the core receives a one-cycle grant. On that clock the memory is read, and written when the strobe is set. One clock later the word that was read comes back on that core's own data lane, together with a one-cycle valid pulse. The memory array lives inside the block.

Top module: `rr_slot_arbiter`

## Requirements
- R1: The slot pointer `slot_o` (a 3-bit core index) starts at 0 after reset. It moves through 0, 1, ..., 7 and back to 0. Each slot lasts `SLOT_CYCLES` clocks (default 2), so a full rotation takes 16 clocks.
- R2: The rotation rate does not depend on the requests. `slot_o` follows the same sequence when no core requests and when all cores request.
- R3: `gnt_o` has at most one bit set. Bit i is set only in the first clock of slot i, and only when `req_i[i]` is high.
- R4: A request raised outside the core's slot gets no grant until the first clock of that core's next slot. The grant then lasts exactly one clock, even while the request stays high.
- R5: One clock after a grant to core i, `rvalid_o` equals the one-hot bit i and lane i of `rdata_o` (bits 32*i+31 down to 32*i) carries the word read. All lanes whose `rvalid_o` bit is low are zero.
- R6: A granted access returns the memory contents as they were before that clock's write (read-first).
- R7: Memory is written only on a granted clock whose owner has its write strobe high. The strobes, addresses and data of cores that are not granted have no effect.
- R8: While `rst_ni` is low, `gnt_o`, `rvalid_o` and `rdata_o` are zero and `slot_o` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-core access request, held until granted |
| we_i | input | 8 | Per-core write strobe |
| addr_i | input | 8*ADDR_W | Per-core word address, lane i at bits ADDR_W*i upward |
| wdata_i | input | 256 | Per-core write data, lane i at bits 32*i upward |
| gnt_o | output | 8 | One-cycle grant, one-hot or zero |
| rvalid_o | output | 8 | Read-data valid, one clock after the grant |
| rdata_o | output | 256 | Per-core read data lanes, zero unless valid |
| slot_o | output | 3 | Index of the core owning the current slot |

## Verification
On every clock, the assertions check the following. The pointer changes only at a slot boundary and wraps from 7 to 0. A grant goes only to the requesting owner of the current slot and never lasts two clocks. The valid pulse copies the previous grant, idle lanes stay at zero, and a memory write happens only for a requesting owner with its strobe set. Some behaviour only the bench scenarios can show, because it needs a reference memory and a cycle count from reset. These are the data values returned, including the read-first result, the exact waiting time of a request raised off its slot, a pointer sequence that is the same with and without load, and proof that strobes from cores outside their slots leave memory untouched.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned N_CORES = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SLOT_W  = $clog2(N_CORES);
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/arb_slot_timer.sv
module arb_slot_timer
  import arb_pkg::*;
#(
  parameter int unsigned SLOT_CYCLES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_t slot_o,
  output logic  slot_start_o
);
  localparam int unsigned CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CYC = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cyc_q;
  slot_t         slot_q;

  // free-running: never looks at requests
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (cyc_q == LAST_CYC) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SLOT_W'(N_CORES - 1)) ? '0 : slot_q + SLOT_W'(1);
    end else begin
      cyc_q  <= cyc_q + CW'(1);
    end
  end

  assign slot_o       = slot_q;
  assign slot_start_o = (cyc_q == '0);

  p_slot_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != $past(slot_q)) |-> ($past(cyc_q) == LAST_CYC));

  p_slot_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(slot_q) == SLOT_W'(N_CORES - 1)) && (slot_q != $past(slot_q))) |-> (slot_q == '0));
endmodule

// File: rtl/arb_port_sel.sv
module arb_port_sel
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                      rst_ni,
  input  slot_t                     slot_i,
  input  logic                      slot_start_i,
  input  logic [N_CORES-1:0]        req_i,
  input  logic [N_CORES-1:0]        we_i,
  input  logic [N_CORES*ADDR_W-1:0] addr_i,
  input  logic [N_CORES*WORD_W-1:0] wdata_i,
  output logic [N_CORES-1:0]        gnt_o,
  output logic                      mem_en_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output word_t                     mem_wdata_o
);
  logic [ADDR_W-1:0] addr_lane [N_CORES];
  word_t             data_lane [N_CORES];

  for (genvar i = 0; i < N_CORES; i++) begin : g_lane
    assign addr_lane[i] = addr_i[i*ADDR_W +: ADDR_W];
    assign data_lane[i] = wdata_i[i*WORD_W +: WORD_W];
  end

  logic owner_req;
  assign owner_req = rst_ni && slot_start_i && req_i[slot_i];

  assign gnt_o       = owner_req ? (N_CORES'(1) << slot_i) : '0;
  assign mem_en_o    = owner_req;
  assign mem_we_o    = owner_req && we_i[slot_i];
  assign mem_addr_o  = addr_lane[slot_i];
  assign mem_wdata_o = data_lane[slot_i];
endmodule

// File: rtl/arb_sram.sv
module arb_sram
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];
  word_t rd_q;

  // read-first: old contents returned on a write
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rd_q <= mem[addr_i];
      if (we_i) mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/rr_slot_arbiter.sv
module rr_slot_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SLOT_CYCLES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CORES-1:0]        req_i,
  input  logic [N_CORES-1:0]        we_i,
  input  logic [N_CORES*ADDR_W-1:0] addr_i,
  input  logic [N_CORES*WORD_W-1:0] wdata_i,
  output logic [N_CORES-1:0]        gnt_o,
  output logic [N_CORES-1:0]        rvalid_o,
  output logic [N_CORES*WORD_W-1:0] rdata_o,
  output logic [SLOT_W-1:0]         slot_o
);
  slot_t             slot;
  logic              slot_start;
  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  word_t             mem_wdata, mem_rdata;
  logic [N_CORES-1:0] rvalid_q;

  arb_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_o       (slot),
    .slot_start_o (slot_start)
  );

  arb_port_sel #(.ADDR_W(ADDR_W)) u_sel (
    .rst_ni       (rst_ni),
    .slot_i       (slot),
    .slot_start_i (slot_start),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .gnt_o        (gnt_o),
    .mem_en_o     (mem_en),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata)
  );

  arb_sram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= '0;
    else         rvalid_q <= gnt_o;
  end

  // only the granted core's lane carries data
  for (genvar i = 0; i < N_CORES; i++) begin : g_ret
    assign rdata_o[i*WORD_W +: WORD_W] = rvalid_q[i] ? mem_rdata : '0;

    p_lane_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rvalid_o[i] |-> (rdata_o[i*WORD_W +: WORD_W] == '0));
  end

  assign rvalid_o = rvalid_q;
  assign slot_o   = slot;

  p_gnt_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (gnt_o[slot_o] && req_i[slot_o]));

  p_gnt_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> ((gnt_o & $past(gnt_o)) == '0));

  p_rvalid_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == $past(gnt_o));

  p_write_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (req_i[slot_o] && we_i[slot_o] && slot_start));
endmodule

// File: tb/rr_slot_arbiter_tb.sv
`timescale 1ns/1ps
module rr_slot_arbiter_tb;
  localparam int AW = 6;
  localparam int S  = 2;
  localparam int N  = 8;
  localparam int W  = 32;

  // entry: core[41:39] we[38] addr[37:32] data[31:0]
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {3'd3, 1'b1, 6'd5,  32'hCAFE_0001},
    {3'd5, 1'b0, 6'd5,  32'h0},
    {3'd0, 1'b1, 6'd5,  32'hBEEF_0002},
    {3'd7, 1'b0, 6'd5,  32'h0},
    {3'd2, 1'b1, 6'd9,  32'h1111_2222},
    {3'd6, 1'b1, 6'd9,  32'h3333_4444},
    {3'd1, 1'b0, 6'd9,  32'h0},
    {3'd4, 1'b1, 6'd63, 32'hFFFF_FFFF},
    {3'd4, 1'b0, 6'd63, 32'h0},
    {3'd0, 1'b1, 6'd0,  32'h1234_5678},
    {3'd7, 1'b0, 6'd0,  32'h0},
    {3'd3, 1'b0, 6'd63, 32'h0}
  };

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   req, we;
  logic [N*AW-1:0] addr;
  logic [N*W-1:0] wdata;
  logic [N-1:0]   gnt, rvalid;
  logic [N*W-1:0] rdata;
  logic [2:0]     slot;

  int checks = 0, errors = 0, t = 0;
  logic [W-1:0] mdl [64];
  bit           mval [64];

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_ni) t <= t + 1;

  rr_slot_arbiter #(.ADDR_W(AW), .SLOT_CYCLES(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata), .slot_o(slot)
  );

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0d)", rq, act, exp, t);
    end
  endtask

  task automatic access(int core, bit w, int a, logic [W-1:0] d, string tag);
    int tg;
    bit early;
    logic [W-1:0] old;
    bit known;
    logic [N*W-1:0] others;
    @(negedge clk);
    req = '0;
    req[core] = 1'b1;
    we[core] = w;
    addr[core*AW +: AW] = AW'(a);
    wdata[core*W +: W] = d;
    #2;
    tg = t;
    while (!((tg % S == 0) && ((tg / S) % N == core))) tg++;
    early = 0;
    while (t != tg) begin
      if (gnt != '0) early = 1;
      @(negedge clk); #2;
    end
    chk(!early, "R4 no grant before own slot", 64'(early), 64'(0));
    chk(gnt == N'(1) << core, "R3 grant to owner", 64'(gnt), 64'(N'(1) << core));
    old = mdl[a];
    known = mval[a];
    @(negedge clk); #2;
    chk(gnt == '0, "R4 single-cycle grant", 64'(gnt), 64'(0));
    chk(rvalid == N'(1) << core, "R5 rvalid to granted core", 64'(rvalid), 64'(N'(1) << core));
    if (known)
      chk(rdata[core*W +: W] == old, tag, 64'(rdata[core*W +: W]), 64'(old));
    others = rdata;
    others[core*W +: W] = '0;
    chk(others == '0, "R5 other lanes zero", 64'(|others), 64'(0));
    if (w) begin
      mdl[a] = d;
      mval[a] = 1;
    end
    req[core] = 1'b0;
    we[core] = 1'b0;
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < 64; i++) mval[i] = 0;
    req = '1; we = '1; addr = '0; wdata = '1;
    #20;
    // R8: reset state regardless of inputs
    chk(gnt == '0, "R8 gnt in reset", 64'(gnt), 64'(0));
    chk(rvalid == '0, "R8 rvalid in reset", 64'(rvalid), 64'(0));
    chk(rdata == '0, "R8 rdata in reset", 64'(|rdata), 64'(0));
    chk(slot == '0, "R8 slot in reset", 64'(slot), 64'(0));
    @(negedge clk);
    req = '0; we = '0;
    rst_ni = 1'b1;

    // R1: pointer sequence with no requests
    bad = 0;
    for (int k = 0; k < 3 * N * S; k++) begin
      @(negedge clk); #2;
      if (slot != 3'((t / S) % N)) bad++;
    end
    chk(bad == 0, "R1 slot sequence idle", 64'(bad), 64'(0));

    // vector table: R3 R4 R5 R6
    for (int v = 0; v < NV; v++)
      access(int'(VEC[v][41:39]), VEC[v][38], int'(VEC[v][37:32]), VEC[v][31:0],
             VEC[v][38] ? "R6 read-first data" : "R5 read data");

    // R2 and R3: all cores requesting
    @(negedge clk);
    req = '1; we = '0; addr = '0;
    bad = 0;
    begin
      int sbad = 0;
      for (int k = 0; k < 2 * N * S; k++) begin
        #2;
        if (slot != 3'((t / S) % N)) sbad++;
        if (gnt != ((t % S == 0) ? (N'(1) << ((t / S) % N)) : N'(0))) bad++;
        @(negedge clk);
      end
      chk(sbad == 0, "R2 slot sequence under full load", 64'(sbad), 64'(0));
    end
    chk(bad == 0, "R3 grant pattern under full load", 64'(bad), 64'(0));
    req = '0;

    // R7: strobes of non-granted cores ignored
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      addr[i*AW +: AW] = AW'(5);
      wdata[i*W +: W] = 32'hDEAD_0000 | 32'(i);
    end
    we = '1;
    repeat (N * S + 2) @(negedge clk);
    access(1, 0, 5, 32'h0, "R7 idle-slot write suppressed");
    we[1] = 1'b1;
    access(6, 0, 5, 32'h0, "R7 non-owner write ignored");
    we = '0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule